// File: doc/BRIEF.md
# Serial Receiver with DMA Block Handshake

This block turns an asynchronous serial line into bytes. It hands each byte to a DMA engine through a level request and a one-cycle read strobe. The serial format is eight data bits, no parity and one stop bit. The line is oversampled OVS times per bit, and each oversample tick lasts CLK_DIV clocks. Each bit is judged from three samples taken around its centre. A completed byte loads the data register and sets a receive-not-empty flag. The flag raises the DMA request when DMA mode is on and blocks remain to be moved.

Software loads a block count, enables reception, and then leaves the engine to drain the bytes. Every accepted strobe clears the receive-not-empty flag and decrements the count. The strobe that takes the count to zero sets a sticky transfer-complete flag. No further requests are made until the count is reloaded.

Framing, noise and overrun conditions are recorded in sticky flags only when the frame that carried them completes. They reach the interrupt line only through their own enable bit.

Top module: `uart_dma_rx`

## Requirements
- R1: The line is read least significant bit first. Each bit's value is the majority of three samples taken on oversample ticks OVS/2-2, OVS/2-1 and OVS/2 of that bit. At the stop bit's centre the byte is loaded into the data register and RXNE (STATUS bit 0) is set.
- R2: `dma_req` is high exactly while RXNE is set, DMA mode (CTRL bit 1) is set and the block count is non-zero.
- R3: A `dma_ack` pulse while `dma_req` is high presents the byte on `dma_data`. It clears RXNE, so the request drops on the next cycle, and it decrements the count by one. A `dma_ack` while `dma_req` is low changes nothing.
- R4: The accepted strobe that takes the count from 1 to 0 sets TC (STATUS bit 4). TC stays set until software writes 1 to STATUS bit 4. With the count at zero no request is made until COUNT is written.
- R5: A frame that completes while RXNE is still set sets ORE (STATUS bit 2). The frame is dropped and the held byte is kept.
- R6: FE (STATUS bit 1) is set when the stop bit's majority is 0. NF (STATUS bit 3) is set when the three samples of any bit of the frame disagree. Neither flag changes before the frame completes.
- R7: FE, ORE and NF are sticky. They clear when a STATUS read is followed by a DATA read, or when a 1 is written to their bit of STATUS.
- R8: `irq` is the OR of three terms: RXNE with CTRL bit 4, TC with CTRL bit 2, and any of FE, ORE or NF with CTRL bit 3. Error flags have no other path to `irq`.
- R9: With DMA mode off, a DATA read clears RXNE. With DMA mode on, a DATA read leaves RXNE set.
- R10: With CTRL bit 0 clear, activity on the serial line has no effect.
- R11: The registers are CTRL at address 0, STATUS at 1, DATA at 2 and COUNT at 3. `reg_rdata` follows `reg_addr` combinationally, and side effects occur only on `reg_rd` or `reg_wr`. After reset every register and flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| dma_req | output | 1 | DMA request level |
| dma_ack | input | 1 | DMA read strobe, one cycle |
| dma_data | output | 8 | Received byte for the DMA engine |
| irq | output | 1 | Interrupt request |

## Verification
A stuck or stale RXNE flag shows on `dma_req` within one clock of the strobe or frame that should have moved it. A miscounted block count shows on `dma_req` and TC as soon as the count is expected to reach zero, and an early count shows as a lost request one byte too soon. A wrong sample window or a wrong majority vote shows as a wrong byte on `dma_data`, or as a wrong NF or FE flag at the end of that same frame. A peek at STATUS in the middle of a frame catches an error flag that appears before the byte completes.

// File: rtl/uart_dma_rx_pkg.sv
package uart_dma_rx_pkg;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_CNT  = 2'd3;

    localparam int CTL_W      = 5;
    localparam int CTL_RXEN   = 0;
    localparam int CTL_DMAEN  = 1;
    localparam int CTL_TCIE   = 2;
    localparam int CTL_ERRIE  = 3;
    localparam int CTL_RXNEIE = 4;

    localparam int ST_W    = 5;
    localparam int ST_RXNE = 0;
    localparam int ST_FE   = 1;
    localparam int ST_ORE  = 2;
    localparam int ST_NF   = 3;
    localparam int ST_TC   = 4;

    typedef struct packed {
        logic [7:0] data;
        logic       ferr;
        logic       noise;
    } rx_frame_t;
endpackage

// File: rtl/uart_dma_rx_tick.sv
module uart_dma_rx_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_count
            logic [DW-1:0] div_d, div_q;
            assign tick = (div_q == DW'(DIV - 1));
            always_comb begin
                if (restart || tick) div_d = '0;
                else                 div_d = div_q + 1'b1;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end
        end
    endgenerate
endmodule

// File: rtl/uart_dma_rx_deser.sv
module uart_dma_rx_deser
    import uart_dma_rx_pkg::*;
#(
    parameter int OVS = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      rx_s,
    input  logic      tick,
    output logic      restart,
    output logic      done,
    output rx_frame_t frame
);
    localparam int CW     = $clog2(OVS);
    localparam int SMP_LO = OVS / 2 - 2;
    localparam int SMP_HI = OVS / 2;
    localparam int STOP_I = 9;

    typedef enum logic {D_IDLE, D_BITS} dstate_e;

    typedef struct packed {
        dstate_e    st;
        logic [CW-1:0] cnt;
        logic [3:0] idx;
        logic [1:0] smp;
        logic [7:0] shreg;
        logic       nz;
        logic       done;
        rx_frame_t  frame;
    } deser_t;

    deser_t d, q;
    logic vote, split;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        restart = 1'b0;
        vote    = (q.smp[1] & q.smp[0]) | (q.smp[1] & rx_s) | (q.smp[0] & rx_s);
        split   = (q.smp[1] ^ q.smp[0]) | (q.smp[0] ^ rx_s);
        case (q.st)
            D_IDLE: begin
                if (en && !rx_s) begin
                    d.st    = D_BITS;
                    d.cnt   = '0;
                    d.idx   = '0;
                    d.nz    = 1'b0;
                    restart = 1'b1;
                end
            end
            default: begin
                if (!en) begin
                    d.st = D_IDLE;
                end else if (tick) begin
                    if (q.cnt >= CW'(SMP_LO) && q.cnt < CW'(SMP_HI))
                        d.smp = {q.smp[0], rx_s};
                    if (q.cnt == CW'(SMP_HI)) begin
                        if (q.idx == 4'd0) begin
                            if (vote) d.st = D_IDLE;
                            else      d.nz = split;
                        end else if (q.idx == 4'(STOP_I)) begin
                            d.done        = 1'b1;
                            d.frame.data  = q.shreg;
                            d.frame.ferr  = ~vote;
                            d.frame.noise = q.nz | split;
                            d.st          = D_IDLE;
                        end else begin
                            d.shreg = {vote, q.shreg[7:1]};
                            d.nz    = q.nz | split;
                        end
                    end
                    if (q.cnt == CW'(OVS - 1)) begin
                        d.cnt = '0;
                        d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done  = q.done;
    assign frame = q.frame;
endmodule

// File: rtl/uart_dma_rx_regs.sv
module uart_dma_rx_regs
    import uart_dma_rx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic             frm_done,
    input  rx_frame_t        frm,
    input  logic             dma_ack,
    output logic             dma_req,
    output logic [7:0]       dma_data,
    output logic             irq,
    output logic             rx_en,
    output logic [ST_W-1:0]  stat,
    output logic [CTL_W-1:0] ctrl,
    output logic [CNT_W-1:0] blk_cnt
);
    typedef struct packed {
        logic [CTL_W-1:0] ctrl;
        logic             rxne;
        logic [7:0]       data;
        logic             fe;
        logic             ore;
        logic             nf;
        logic             tc;
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t d, q;
    logic take, rd_data;

    always_comb begin
        d       = q;
        dma_req = q.rxne & q.ctrl[CTL_DMAEN] & (q.cnt != '0);
        take    = dma_ack & dma_req;
        rd_data = reg_rd && (reg_addr == A_DATA);

        if (take) begin
            d.rxne = 1'b0;
            d.cnt  = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) d.tc = 1'b1;
        end
        if (rd_data) begin
            if (!q.ctrl[CTL_DMAEN]) d.rxne = 1'b0;
            if (q.armed) begin
                d.fe  = 1'b0;
                d.ore = 1'b0;
                d.nf  = 1'b0;
            end
            d.armed = 1'b0;
        end
        if (reg_rd && (reg_addr == A_STAT)) d.armed = 1'b1;
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: d.ctrl = reg_wdata[CTL_W-1:0];
                A_STAT: begin
                    if (reg_wdata[ST_FE])  d.fe  = 1'b0;
                    if (reg_wdata[ST_ORE]) d.ore = 1'b0;
                    if (reg_wdata[ST_NF])  d.nf  = 1'b0;
                    if (reg_wdata[ST_TC])  d.tc  = 1'b0;
                end
                A_CNT:  d.cnt = reg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
        if (frm_done) begin
            if (d.rxne) begin
                d.ore = 1'b1;
            end else begin
                d.rxne = 1'b1;
                d.data = frm.data;
                d.fe   = d.fe | frm.ferr;
                d.nf   = d.nf | frm.noise;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stat     = {q.tc, q.nf, q.ore, q.fe, q.rxne};
    assign ctrl     = q.ctrl;
    assign blk_cnt  = q.cnt;
    assign rx_en    = q.ctrl[CTL_RXEN];
    assign dma_data = q.data;
    assign irq      = (q.ctrl[CTL_RXNEIE] & q.rxne)
                    | (q.ctrl[CTL_TCIE] & q.tc)
                    | (q.ctrl[CTL_ERRIE] & (q.fe | q.ore | q.nf));

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = 16'(q.ctrl);
            A_STAT:  reg_rdata = 16'(stat);
            A_DATA:  reg_rdata = 16'(q.data);
            default: reg_rdata = 16'(q.cnt);
        endcase
    end
endmodule

// File: rtl/uart_dma_rx.sv
module uart_dma_rx
    import uart_dma_rx_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int OVS     = 8,
    parameter int CNT_W   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_i,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        dma_req,
    input  logic        dma_ack,
    output logic [7:0]  dma_data,
    output logic        irq
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = rx_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    logic             tick, restart, frm_done, rx_en;
    rx_frame_t        frm;
    logic [ST_W-1:0]  stat_w;
    logic [CTL_W-1:0] ctrl_w;
    logic [CNT_W-1:0] cnt_w;

    uart_dma_rx_tick #(.DIV(CLK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    uart_dma_rx_deser #(.OVS(OVS)) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_en),
        .rx_s    (sync_q.s2),
        .tick    (tick),
        .restart (restart),
        .done    (frm_done),
        .frame   (frm)
    );

    uart_dma_rx_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .frm_done  (frm_done),
        .frm       (frm),
        .dma_ack   (dma_ack),
        .dma_req   (dma_req),
        .dma_data  (dma_data),
        .irq       (irq),
        .rx_en     (rx_en),
        .stat      (stat_w),
        .ctrl      (ctrl_w),
        .blk_cnt   (cnt_w)
    );
endmodule

// File: rtl/uart_dma_rx_chk.sv
module uart_dma_rx_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_done,
    input logic             dma_req,
    input logic             dma_ack,
    input logic [7:0]       dma_data,
    input logic             irq,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [1:0]       reg_addr,
    input logic [15:0]      reg_wdata,
    input logic [4:0]       stat,
    input logic [4:0]       ctrl,
    input logic [CNT_W-1:0] blk_cnt
);
    AST_REQ_NEEDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (stat[0] && ctrl[1] && blk_cnt != '0)); // R2

    AST_REQ_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack && !frm_done) |=> !dma_req); // R3

    AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[4] && !(reg_wr && reg_addr == 2'd1 && reg_wdata[4])) |=> stat[4]); // R4

    AST_ZERO_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_cnt == '0 && !(reg_wr && reg_addr == 2'd3)) |=> blk_cnt == '0); // R4

    AST_OVERRUN_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[0] && frm_done && !dma_ack && !(reg_rd && reg_addr == 2'd2))
        |=> (stat[2] && $stable(dma_data))); // R5

    AST_FE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[1]) |-> $past(frm_done)); // R6

    AST_NF_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[3]) |-> $past(frm_done)); // R6

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl[2] || ctrl[3] || ctrl[4])); // R8
endmodule

bind uart_dma_rx uart_dma_rx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_done  (frm_done),
    .dma_req   (dma_req),
    .dma_ack   (dma_ack),
    .dma_data  (dma_data),
    .irq       (irq),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .stat      (stat_w),
    .ctrl      (ctrl_w),
    .blk_cnt   (cnt_w)
);

// File: tb/uart_dma_rx_tb.sv
module uart_dma_rx_tb;
    localparam int DIV  = 2;
    localparam int OVS  = 8;
    localparam int BITC = DIV * OVS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic        dma_ack = 1'b0;
    logic [15:0] reg_rdata;
    logic        dma_req;
    logic [7:0]  dma_data;
    logic        irq;

    always #10 clk = ~clk;

    uart_dma_rx #(.CLK_DIV(DIV), .OVS(OVS), .CNT_W(16)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_i      (rx),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dma_req   (dma_req),
        .dma_ack   (dma_ack),
        .dma_data  (dma_data),
        .irq       (irq)
    );

    int checks = 0;
    int errors = 0;
    bit settled = 1'b0;

    bit       m_rxne, m_fe, m_ore, m_nf, m_tc, m_armed;
    bit [7:0] m_data;
    int       m_cnt;
    bit [4:0] m_ctrl;

    function automatic bit exp_req();
        return m_rxne && m_ctrl[1] && (m_cnt != 0);
    endfunction

    function automatic bit exp_irq();
        return (m_ctrl[4] && m_rxne) || (m_ctrl[2] && m_tc) ||
               (m_ctrl[3] && (m_fe || m_ore || m_nf));
    endfunction

    function automatic int stat_word();
        return {m_tc, m_nf, m_ore, m_fe, m_rxne};
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison of the handshake and interrupt lines
    always @(posedge clk) begin
        #5;
        if (settled && rst_n) begin
            chk("R2 dma_req", int'(dma_req), int'(exp_req()));
            chk("R8 irq", int'(irq), int'(exp_irq()));
        end
    end

    task automatic wr(logic [1:0] a, logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        case (a)
            2'd0: m_ctrl = v[4:0];
            2'd1: begin
                if (v[1]) m_fe = 1'b0;
                if (v[2]) m_ore = 1'b0;
                if (v[3]) m_nf = 1'b0;
                if (v[4]) m_tc = 1'b0;
            end
            2'd3: m_cnt = int'(v);
            default: ;
        endcase
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, int exp, string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 chk(tag, int'(reg_rdata), exp);
        if (a == 2'd2) begin
            if (!m_ctrl[1]) m_rxne = 1'b0;
            if (m_armed) begin m_fe = 1'b0; m_ore = 1'b0; m_nf = 1'b0; end
            m_armed = 1'b0;
        end
        if (a == 2'd1) m_armed = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic ack(string tag);
        bit hit;
        @(negedge clk);
        dma_ack = 1'b1;
        hit = exp_req();
        #1;
        if (hit) begin
            chk(tag, int'(dma_data), int'(m_data));
            m_rxne = 1'b0;
            m_cnt--;
            if (m_cnt == 0) m_tc = 1'b1;
        end
        @(negedge clk);
        dma_ack = 1'b0;
    endtask

    task automatic send(logic [7:0] b, bit stop, int nz_bit, bit mid_peek);
        bit v;
        settled = 1'b0;
        for (int i = 0; i < 10; i++) begin
            v = (i == 0) ? 1'b0 : (i == 9) ? stop : b[i-1];
            @(negedge clk);
            rx = v;
            if (mid_peek && i == 6) begin
                reg_addr = 2'd1;
                #1 chk("R6 no flag mid-frame", int'(reg_rdata), stat_word());
            end
            if (i == nz_bit) begin
                repeat (BITC / 2) @(negedge clk);
                rx = ~v;
                @(negedge clk);
                rx = v;
                repeat (BITC / 2 - 2) @(negedge clk);
            end else begin
                repeat (BITC - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        rx = 1'b1;
        repeat (14) @(negedge clk);
        if (m_ctrl[0]) begin
            if (m_rxne) begin
                m_ore = 1'b1;
            end else begin
                m_rxne = 1'b1;
                m_data = b;
                if (!stop) m_fe = 1'b1;
                if (nz_bit >= 0) m_nf = 1'b1;
            end
        end
        settled = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settled = 1'b1;

        // R11 reset state
        rd(2'd1, 0, "R11 status after reset");
        rd(2'd3, 0, "R11 count after reset");
        rd(2'd0, 0, "R11 ctrl after reset");

        wr(2'd3, 16'd3);
        wr(2'd0, 16'h000F);
        rd(2'd0, 16'h000F, "R11 ctrl readback");

        // R1 clean byte, R2/R3 handshake
        send(8'hA5, 1'b1, -1, 1'b0);
        chk("R1 rxne set", int'(dma_req), 1);
        ack("R3 data A5");
        rd(2'd3, 2, "R3 count after ack");

        // R6 noise in one bit, flag only at frame end; majority keeps data
        send(8'h3C, 1'b1, 3, 1'b1);
        rd(2'd1, stat_word(), "R6 nf after frame");
        ack("R1 R6 data 3C despite glitch");
        chk("R8 err irq", int'(irq), 1);
        wr(2'd1, 16'h0008);
        rd(2'd1, 0, "R7 nf cleared by w1c");

        // R6 framing error; R4 count to zero sets TC
        send(8'h0F, 1'b0, -1, 1'b0);
        ack("R6 data 0F");
        rd(2'd1, 16'h0012, "R4 tc and fe set");

        // R4 no request at zero count; R3 stray ack ignored
        send(8'h77, 1'b1, -1, 1'b0);
        chk("R4 no req at zero count", int'(dma_req), 0);
        ack("R3 ignored ack");
        rd(2'd3, 0, "R3 stray ack keeps count");
        rd(2'd1, 16'h0013, "R3 stray ack keeps rxne");

        // R5 overrun keeps old byte
        send(8'h12, 1'b1, -1, 1'b0);
        rd(2'd1, 16'h0017, "R5 ore set");
        rd(2'd2, 16'h0077, "R5 old byte kept");
        rd(2'd1, 16'h0011, "R7 R9 errors cleared, rxne kept in dma mode");

        // R4 reload after complete
        wr(2'd1, 16'h0010);
        wr(2'd3, 16'd1);
        chk("R4 req after reload", int'(dma_req), 1);
        ack("R4 data 77 after reload");
        rd(2'd1, 16'h0010, "R4 tc again");
        wr(2'd1, 16'h0010);

        // R9 cpu mode with rxne interrupt
        wr(2'd0, 16'h0011);
        send(8'h81, 1'b1, -1, 1'b0);
        chk("R8 rxne irq", int'(irq), 1);
        rd(2'd2, 16'h0081, "R9 cpu data");
        rd(2'd1, 0, "R9 rxne cleared by cpu read");

        // R10 receiver disabled
        wr(2'd0, 16'h0010);
        send(8'hC3, 1'b1, -1, 1'b0);
        rd(2'd1, 0, "R10 disabled line ignored");

        // R8 error only via its own enable
        wr(2'd0, 16'h0001);
        send(8'h55, 1'b0, -1, 1'b0);
        chk("R8 fe without err enable", int'(irq), 0);
        wr(2'd0, 16'h0009);
        chk("R8 fe with err enable", int'(irq), 1);
        rd(2'd2, 16'h0055, "R1 data 55");

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule